// File: doc/BRIEF.md
# Next-Interrupt CSR Access Unit

This block computes the response to an access of the "next interrupt" control register. An interrupt handler uses that register to pick up further vectored interrupts back to back without returning from the trap. On every access the unit searches the per-interrupt pending, level, vectoring and trigger-type fields for the best pending interrupt that is allowed to preempt. To be allowed, the interrupt must be vectored and its level must be above both the saved previous level and the threshold. The unit returns that interrupt's vector table entry address as read data, or zero when no interrupt qualifies.

The access type decides the side effects. A plain read only reports the address. A claiming access reports the address and also raises write strobes. These strobes load the current interrupt level and the exception code with the chosen interrupt's level and ID. When that interrupt is edge-triggered, a strobe also clears its pending bit. Reserved encodings raise an illegal-access flag and have no other effect. All strobes are combinational in the access cycle, so the registers that hold this state, which sit outside the unit, are already updated for an access in the following cycle.

Top module: `next_irq_csr`

## Requirements
- R1: An interrupt qualifies only if all of the following hold: its `irqPending` bit is 1, its `irqVectored` bit is 1, its level is strictly greater than `prevLevel`, and its level is strictly greater than `threshold`.
- R2: Among the qualifying interrupts, the one with the highest level is selected. When levels tie, the higher interrupt ID wins.
- R3: When an interrupt is selected, the returned address is `tableBase + ID * (XLEN/8)`. The level of interrupt i is taken from `irqLevel[i*LVL_W +: LVL_W]`.
- R4: A pure read is `accOp` 2 or 6 with `accOperand` equal to zero. It returns the address (or zero when nothing qualifies) and raises no strobe and no illegal flag.
- R5: A claim is `accOp` 7 with any operand, or `accOp` 2 or 6 with a non-zero operand that has no bit set other than bits 1 and 3. When an interrupt is selected, a claim returns its address, pulses `levelWe` with `levelWdata` equal to its level, and pulses `causeWe` with `causeId` equal to its ID.
- R6: On a claim, `clrPend` carries a one-hot bit at the selected ID only when that interrupt's `irqEdge` bit is 1 (edge-triggered). For a level-triggered interrupt, `clrPend` is zero.
- R7: The following accesses are reserved: `accOp` 0, 1, 3, 4 and 5, and `accOp` 2 or 6 with any operand bit set outside bits 1 and 3. A reserved access sets `illegal`, returns zero, and raises no level, cause or pending-clear strobe.
- R8: A claim when nothing qualifies returns zero and raises no strobe and no illegal flag.
- R9: While `accValid` is low, all outputs are zero.
- R10: While `rstN` is low, and until the first rising `clk` edge with `rstN` high, all outputs are zero.
- R11: All strobes appear in the same cycle as the access. An access in the next cycle, made against the fed-back pending bits, therefore no longer selects an interrupt whose pending bit was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPending | input | NUM_IRQ | Pending bit per interrupt |
| irqLevel | input | NUM_IRQ*LVL_W | Packed levels, interrupt i at bits i*LVL_W upward |
| irqVectored | input | NUM_IRQ | 1 = interrupt uses vectored handling |
| irqEdge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| prevLevel | input | LVL_W | Saved level of the interrupted context |
| threshold | input | LVL_W | Interrupt level threshold |
| tableBase | input | XLEN | Vector table base address |
| accValid | input | 1 | An access to the register happens this cycle |
| accOp | input | 3 | Access operation code (see R4, R5, R7) |
| accOperand | input | XLEN | Source register value or zero-extended immediate |
| rdData | output | XLEN | Read data: entry address or zero |
| levelWe | output | 1 | Load current interrupt level |
| levelWdata | output | LVL_W | New current interrupt level |
| causeWe | output | 1 | Load exception code |
| causeId | output | $clog2(NUM_IRQ) | New exception code (interrupt ID) |
| clrPend | output | NUM_IRQ | One-hot clear of an edge-triggered pending bit |
| illegal | output | 1 | Reserved access form |

## Verification
The bench builds the unit with eight interrupts, 4-bit levels and a 32-bit word. The narrow level field makes equal levels, and levels equal to the previous level or to the threshold, frequent under random stimulus. This exercises the strict comparisons and the highest-ID tie break on almost every access. Random operands are drawn partly from the values 0, 2, 8 and 10, which reaches the boundary between read, claim and reserved. The bench feeds the pending-clear strobe back into its pending register, so consecutive claims drain the edge-triggered interrupts one after another.

// File: rtl/next_irq_csr_pkg.sv
package next_irq_csr_pkg;

  typedef enum logic [2:0] {
    OP_RSV0 = 3'd0,
    OP_RW   = 3'd1,
    OP_RS   = 3'd2,
    OP_RC   = 3'd3,
    OP_RSV4 = 3'd4,
    OP_RWI  = 3'd5,
    OP_RSI  = 3'd6,
    OP_RCI  = 3'd7
  } csrOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic claimEn;
    logic illegal;
  } ctrlStrobeT;

  // Operand bits that may be set on a set-type claim
  localparam int unsigned CLAIM_BITS = 32'h0000_000A;

endpackage

// File: rtl/next_irq_csr_ctrl.sv
module next_irq_csr_ctrl
  import next_irq_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [2:0]       accOp,
  input  logic [XLEN-1:0]  accOperand,
  output ctrlStrobeT       strobe
);

  localparam logic [XLEN-1:0] ALLOWED = XLEN'(CLAIM_BITS);

  logic armed;
  logic live;
  logic zeroOperand;
  logic strayBits;
  ctrlStrobeT decoded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign live        = accValid && armed && rstN;
  assign zeroOperand = (accOperand == '0);
  assign strayBits   = |(accOperand & ~ALLOWED);

  always_comb begin
    decoded = '0;
    unique case (csrOpE'(accOp))
      OP_RS, OP_RSI: begin
        if (zeroOperand)     decoded.rdEn    = 1'b1;
        else if (!strayBits) decoded.claimEn = 1'b1;
        else                 decoded.illegal = 1'b1;
      end
      OP_RCI:  decoded.claimEn = 1'b1;
      default: decoded.illegal = 1'b1;
    endcase
  end

  assign strobe = live ? decoded : '0;

endmodule

// File: rtl/next_irq_csr_dp.sv
module next_irq_csr_dp
  import next_irq_csr_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 8,
  parameter int XLEN    = 32
) (
  input  ctrlStrobeT                   strobe,
  input  logic [NUM_IRQ-1:0]           irqPending,
  input  logic [NUM_IRQ*LVL_W-1:0]     irqLevel,
  input  logic [NUM_IRQ-1:0]           irqVectored,
  input  logic [NUM_IRQ-1:0]           irqEdge,
  input  logic [LVL_W-1:0]             prevLevel,
  input  logic [LVL_W-1:0]             threshold,
  input  logic [XLEN-1:0]              tableBase,
  output logic [XLEN-1:0]              rdData,
  output logic                         levelWe,
  output logic [LVL_W-1:0]             levelWdata,
  output logic                         causeWe,
  output logic [$clog2(NUM_IRQ)-1:0]   causeId,
  output logic [NUM_IRQ-1:0]           clrPend,
  output logic                         illegal
);

  localparam int ID_W     = $clog2(NUM_IRQ);
  localparam int ADDR_SH  = $clog2(XLEN / 8);

  logic [NUM_IRQ-1:0] qual;
  logic [LVL_W-1:0]   lvlOf [NUM_IRQ];

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : gQual
      assign lvlOf[g] = irqLevel[g*LVL_W +: LVL_W];
      assign qual[g]  = irqPending[g] && irqVectored[g] &&
                        (lvlOf[g] > prevLevel) && (lvlOf[g] > threshold);
    end
  endgenerate

  logic             hit;
  logic [ID_W-1:0]  selId;
  logic [LVL_W-1:0] selLevel;

  // Ascending scan with >= lets a later (higher) ID win a tie
  always_comb begin
    hit      = 1'b0;
    selId    = '0;
    selLevel = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (qual[i] && (!hit || lvlOf[i] >= selLevel)) begin
        hit      = 1'b1;
        selId    = ID_W'(i);
        selLevel = lvlOf[i];
      end
    end
  end

  logic [XLEN-1:0] entryAddr;
  logic            claim;

  assign entryAddr = tableBase + (XLEN'(selId) << ADDR_SH);
  assign claim     = strobe.claimEn && hit;

  assign rdData     = ((strobe.rdEn || strobe.claimEn) && hit) ? entryAddr : '0;
  assign levelWe    = claim;
  assign levelWdata = claim ? selLevel : '0;
  assign causeWe    = claim;
  assign causeId    = claim ? selId : '0;
  assign clrPend    = (claim && irqEdge[selId]) ? (NUM_IRQ'(1) << selId) : '0;
  assign illegal    = strobe.illegal;

endmodule

// File: rtl/next_irq_csr.sv
module next_irq_csr
  import next_irq_csr_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 8,
  parameter int XLEN    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_IRQ-1:0]           irqPending,
  input  logic [NUM_IRQ*LVL_W-1:0]     irqLevel,
  input  logic [NUM_IRQ-1:0]           irqVectored,
  input  logic [NUM_IRQ-1:0]           irqEdge,
  input  logic [LVL_W-1:0]             prevLevel,
  input  logic [LVL_W-1:0]             threshold,
  input  logic [XLEN-1:0]              tableBase,
  input  logic                         accValid,
  input  logic [2:0]                   accOp,
  input  logic [XLEN-1:0]              accOperand,
  output logic [XLEN-1:0]              rdData,
  output logic                         levelWe,
  output logic [LVL_W-1:0]             levelWdata,
  output logic                         causeWe,
  output logic [$clog2(NUM_IRQ)-1:0]   causeId,
  output logic [NUM_IRQ-1:0]           clrPend,
  output logic                         illegal
);

  ctrlStrobeT strobe;

  next_irq_csr_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .accOp      (accOp),
    .accOperand (accOperand),
    .strobe     (strobe)
  );

  next_irq_csr_dp #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .XLEN(XLEN)) u_dp (
    .strobe      (strobe),
    .irqPending  (irqPending),
    .irqLevel    (irqLevel),
    .irqVectored (irqVectored),
    .irqEdge     (irqEdge),
    .prevLevel   (prevLevel),
    .threshold   (threshold),
    .tableBase   (tableBase),
    .rdData      (rdData),
    .levelWe     (levelWe),
    .levelWdata  (levelWdata),
    .causeWe     (causeWe),
    .causeId     (causeId),
    .clrPend     (clrPend),
    .illegal     (illegal)
  );

endmodule

// File: rtl/next_irq_csr_chk.sv
module next_irq_csr_chk #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 8,
  parameter int XLEN    = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_IRQ-1:0]           irqPending,
  input logic [NUM_IRQ*LVL_W-1:0]     irqLevel,
  input logic [NUM_IRQ-1:0]           irqVectored,
  input logic [NUM_IRQ-1:0]           irqEdge,
  input logic [LVL_W-1:0]             prevLevel,
  input logic [LVL_W-1:0]             threshold,
  input logic [XLEN-1:0]              tableBase,
  input logic                         accValid,
  input logic [2:0]                   accOp,
  input logic [XLEN-1:0]              accOperand,
  input logic [XLEN-1:0]              rdData,
  input logic                         levelWe,
  input logic [LVL_W-1:0]             levelWdata,
  input logic                         causeWe,
  input logic [$clog2(NUM_IRQ)-1:0]   causeId,
  input logic [NUM_IRQ-1:0]           clrPend,
  input logic                         illegal
);

  AST_CLAIM_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    levelWe |-> (irqPending[causeId] && irqVectored[causeId] &&
                 levelWdata > prevLevel && levelWdata > threshold)); // R1

  AST_CLAIM_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    levelWe |-> (irqLevel[causeId*LVL_W +: LVL_W] == levelWdata)); // R5

  AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrPend)); // R6

  AST_CLEAR_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (clrPend != '0) |-> (levelWe && (clrPend & ~irqEdge) == '0)); // R6

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!levelWe && !causeWe && clrPend == '0 && rdData == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!illegal && !levelWe && rdData == '0)); // R9

endmodule

bind next_irq_csr next_irq_csr_chk #(
  .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .XLEN(XLEN)
) u_chk (.*);

// File: tb/next_irq_csr_tb.sv
module next_irq_csr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int LW = 4;
  localparam int XL = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]    pend = '0, vect = '0, edg = '0;
  logic [LW-1:0]   lvl [N];
  logic [N*LW-1:0] irqLevel;
  logic [LW-1:0]   prevLevel = '0, threshold = '0;
  logic [XL-1:0]   tableBase = '0;
  logic            accValid = 1'b0;
  logic [2:0]      accOp = '0;
  logic [XL-1:0]   accOperand = '0;
  logic [XL-1:0]   rdData;
  logic            levelWe, causeWe, illegal;
  logic [LW-1:0]   levelWdata;
  logic [IW-1:0]   causeId;
  logic [N-1:0]    clrPend;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < N; i++) irqLevel[i*LW +: LW] = lvl[i];

  next_irq_csr #(.NUM_IRQ(N), .LVL_W(LW), .XLEN(XL)) u_dut (
    .clk(clk), .rstN(rstN), .irqPending(pend), .irqLevel(irqLevel),
    .irqVectored(vect), .irqEdge(edg), .prevLevel(prevLevel),
    .threshold(threshold), .tableBase(tableBase), .accValid(accValid),
    .accOp(accOp), .accOperand(accOperand), .rdData(rdData),
    .levelWe(levelWe), .levelWdata(levelWdata), .causeWe(causeWe),
    .causeId(causeId), .clrPend(clrPend), .illegal(illegal)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 read, 1 claim, 2 reserved, 3 no access
  function automatic int kindOf(logic v, logic [2:0] op, logic [XL-1:0] opnd);
    if (!v) return 3;
    if (op == 3'd7) return 1;
    if (op == 3'd2 || op == 3'd6) begin
      if (opnd == '0) return 0;
      if ((opnd & ~XL'(10)) == '0) return 1;
    end
    return 2;
  endfunction

  // Inputs set at a negedge; sample 2 units later; feed clears back at posedge
  task automatic step(string req);
    int best = -1;
    int k;
    logic [XL-1:0] eRd;
    logic eClaim;
    logic [N-1:0] eClr, seenClr;
    #2;
    for (int i = 0; i < N; i++)
      if (pend[i] && vect[i] && lvl[i] > prevLevel && lvl[i] > threshold)
        if (best < 0 || lvl[i] >= lvl[best]) best = i;
    k = kindOf(accValid, accOp, accOperand);
    eRd    = (k <= 1 && best >= 0) ? tableBase + XL'(best) * (XL/8) : '0;
    eClaim = (k == 1 && best >= 0);
    eClr   = (eClaim && edg[best]) ? (N'(1) << best) : '0;
    chk(req, "rdData", 64'(rdData), 64'(eRd));
    chk(req, "levelWe", 64'(levelWe), 64'(eClaim));
    chk(req, "causeWe", 64'(causeWe), 64'(eClaim));
    if (eClaim) begin
      chk(req, "levelWdata", 64'(levelWdata), 64'(lvl[best]));
      chk(req, "causeId", 64'(causeId), 64'(best));
    end
    chk(req, "clrPend", 64'(clrPend), 64'(eClr));
    chk(req, "illegal", 64'(illegal), 64'(k == 2));
    seenClr = clrPend;
    @(posedge clk);
    pend = pend & ~seenClr;
    @(negedge clk);
  endtask

  task automatic access(logic [2:0] op, logic [XL-1:0] opnd);
    accValid = 1'b1; accOp = op; accOperand = opnd;
  endtask

  task automatic quietCheck(string req);
    #2;
    chk(req, "rdData", 64'(rdData), 64'd0);
    chk(req, "levelWe", 64'(levelWe), 64'd0);
    chk(req, "clrPend", 64'(clrPend), 64'd0);
    chk(req, "illegal", 64'(illegal), 64'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) lvl[i] = LW'(i + 1);
    pend = '1; vect = '1; edg = '1;
    tableBase = 32'h0000_4000;
    access(3'd7, '0);
    // R10: reset asserted with a claim presented
    @(negedge clk); quietCheck("R10");
    rstN = 1'b1;
    quietCheck("R10"); // not yet armed
    @(negedge clk);

    // R9: no access
    accValid = 1'b0;
    step("R9");

    // R3/R4: pure read of highest level (ID 7, level 8)
    access(3'd2, '0); step("R4");
    chk("R3", "pend untouched", 64'(pend), 64'hFF);
    access(3'd6, '0); step("R3");

    // R1: non-vectored, equal to prev, equal to threshold
    vect = 8'b0111_1111; prevLevel = 4'd6; threshold = 4'd2;
    access(3'd2, '0); step("R1"); // only ID 6 (level 7) qualifies
    prevLevel = 4'd2; threshold = 4'd7;
    access(3'd2, '0); step("R1"); // nothing qualifies
    vect = '1; threshold = 4'd0; prevLevel = 4'd0;

    // R2: tie at top level, higher ID wins
    lvl[2] = 4'd15; lvl[5] = 4'd15;
    access(3'd2, '0); step("R2");

    // R5/R6: claims with operands 2, 8, 10 and RCI; edge clears
    access(3'd2, 32'd2);  step("R5");   // claims ID 5
    access(3'd6, 32'd8);  step("R6");   // ID 2 next
    // R6: level-triggered, bit stays
    edg = 8'b0111_1111;
    access(3'd7, 32'd31); step("R6");   // ID 7 level 8, no clear
    chk("R6", "level pend kept", 64'(pend[7]), 64'd1);
    // R11: back-to-back claims drain edge interrupts
    pend = 8'b0000_0011; edg = '1;
    access(3'd6, 32'd10); step("R11");
    access(3'd6, 32'd10); step("R11");
    access(3'd6, 32'd10); step("R8");   // nothing left
    chk("R11", "pend drained", 64'(pend), 64'd0);

    // R7: reserved encodings leave pending bits untouched
    pend = '1;
    access(3'd1, '0);     step("R7");
    access(3'd3, '0);     step("R7");
    access(3'd5, 32'd2);  step("R7");
    access(3'd0, '0);     step("R7");
    access(3'd4, '0);     step("R7");
    access(3'd6, 32'd1);  step("R7");
    access(3'd2, 32'd16); step("R7");
    chk("R7", "pend untouched", 64'(pend), 64'hFF);

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      int sel;
      int k;
      string tag;
      if ((it % 6) == 0 || pend == '0) pend = N'($urandom);
      vect = N'($urandom) | N'($urandom);
      edg  = N'($urandom);
      for (int i = 0; i < N; i++) lvl[i] = LW'($urandom);
      prevLevel = LW'($urandom_range(0, 8));
      threshold = LW'($urandom_range(0, 8));
      tableBase = $urandom & 32'hFFFF_FFC0;
      accValid  = ($urandom_range(0, 9) != 0);
      accOp     = 3'($urandom);
      sel = $urandom_range(0, 5);
      case (sel)
        0: accOperand = 32'd0;
        1: accOperand = 32'd2;
        2: accOperand = 32'd8;
        3: accOperand = 32'd10;
        4: accOperand = XL'($urandom_range(0, 31));
        default: accOperand = $urandom;
      endcase
      k = kindOf(accValid, accOp, accOperand);
      tag = (k == 0) ? "R4" : (k == 1) ? "R5" : (k == 2) ? "R7" : "R9";
      step(tag);
    end

    finishRun();
  end

endmodule